// File: doc/BRIEF.md
# In-band flow control transmit gate

This block sits between the receive and transmit halves of one serial channel. It supplies the in-band (software) flow control. Every character that the receiver offers for storage passes through it. When automatic transmit gating is on, the block compares each character against two programmable codes: a resume code and a stop code. A stop code halts the local transmitter once the character in flight has gone out. A resume code lets the transmitter run again.

Only characters that actually find room in the receive FIFO count. A flow character that arrives into a full FIFO is lost, and it has no effect on the transmitter. A break is treated as the data value 0x00 and is compared like any other character. A transparency input selects whether recognised flow characters are also stored in the receive FIFO or dropped. Error flags always travel with the character.

In host mode the gate ignores flow characters. Host commands then enable and disable the transmitter. In automatic mode those host commands have no effect. A soft transmitter reset releases the gate and pulses a flush request to the transmit FIFO.

Top module: `xtg_top`

## Requirements
- R1: After `rst_n` is asserted, the gate is running (`tx_paused`=0, `tx_halted`=0), `tx_flush`=0 and the host enable is cleared, so `tx_pop_ok`=0 while `auto_en`=0.
- R2: In automatic mode, an accepted stop character (`rx_valid`=1, `rx_full`=0, data equal to `xoff_code`) in cycle t sets `tx_paused` and clears `tx_pop_ok` from cycle t+1.
- R3: After such a stop character, `tx_halted` rises one cycle after the first cycle, from t onward, in which `tx_busy` is low. Until then the gate stays paused but not halted.
- R4: In automatic mode, an accepted resume character (data equal to `xon_code`) clears `tx_paused` and `tx_halted` from the next cycle.
- R5: `tx_soft_rst` high in cycle t returns the gate to running in t+1 and raises `tx_flush` for exactly that one cycle. It takes priority over any flow character in the same cycle.
- R6: With `auto_en`=0, `host_dis_cmd` clears and `host_en_cmd` sets the host enable from the next cycle (disable wins if both are high), and `tx_pop_ok` follows that enable. With `auto_en`=1, both commands are ignored and `tx_pop_ok` is high exactly when the gate is not paused.
- R7: A character offered while `rx_full`=1 is not pushed (`rx_push`=0) and does not change the gate state, whatever its value and the transparency setting.
- R8: `rx_push` = `rx_valid` and not `rx_full`, except that in automatic mode a flow character is pushed only when `transparent`=1.
- R9: A flow character that carries error flags still gates the transmitter. `rx_push_err` always equals `rx_err` for the offered character.
- R10: When `rx_break`=1, the offered data is taken as 0x00 for both comparison and `rx_push_data`. A break therefore acts as a flow character when a code is 0x00.
- R11: When `xon_code` equals `xoff_code`, a matching character acts as a stop character.
- R12: With `auto_en`=0, flow characters have no effect and are stored as ordinary data. Clearing `auto_en` returns a paused gate to running in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| auto_en | input | 1 | Automatic transmit gating on flow characters |
| transparent | input | 1 | Also store recognised flow characters |
| xon_code | input | DATA_W | Resume character code |
| xoff_code | input | DATA_W | Stop character code |
| rx_valid | input | 1 | Receiver offers a character this cycle |
| rx_data | input | DATA_W | Offered character |
| rx_break | input | 1 | Offered character is a break (data taken as zero) |
| rx_err | input | ERR_W | Error flags of the offered character |
| rx_full | input | 1 | Receive FIFO has no room |
| tx_busy | input | 1 | Transmit shifter is sending a character |
| tx_soft_rst | input | 1 | Soft transmitter reset command |
| host_en_cmd | input | 1 | Host command: enable transmitter |
| host_dis_cmd | input | 1 | Host command: disable transmitter |
| rx_push | output | 1 | Push offered character into receive FIFO |
| rx_push_data | output | DATA_W | Data to push |
| rx_push_err | output | ERR_W | Error flags to push |
| tx_pop_ok | output | 1 | Transmitter may load its next character |
| tx_paused | output | 1 | Gate stopped by a flow character |
| tx_halted | output | 1 | Stopped and the last character has finished |
| tx_flush | output | 1 | One-cycle request to discard the transmit FIFO |

## Verification
A gate state that is wrong shows up at `tx_pop_ok` and `tx_paused` in the cycle after the flow character that caused it. A missed drain step shows as `tx_halted` rising early or late, relative to the cycle in which `tx_busy` falls. Wrong detector or transparency decisions appear in the same cycle on `rx_push` and `rx_push_data`. A lost host enable stays hidden until automatic mode is left, and then it appears on `tx_pop_ok`. The reference model therefore compares every output on every clock, across mode changes.

// File: rtl/xtg_pkg.sv
package xtg_pkg;
    typedef enum logic [1:0] {
        GATE_RUN   = 2'd0,
        GATE_DRAIN = 2'd1,
        GATE_HALT  = 2'd2
    } gate_state_e;

    typedef struct packed {
        gate_state_e state;
        logic        flush;
    } gate_regs_t;
endpackage

// File: rtl/xtg_flow_detect.sv
module xtg_flow_detect #(
    parameter int DATA_W = 8,
    parameter int ERR_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              auto_en,
    input  logic              transparent,
    input  logic [DATA_W-1:0] xon_code,
    input  logic [DATA_W-1:0] xoff_code,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rx_break,
    input  logic [ERR_W-1:0]  rx_err,
    input  logic              rx_full,
    output logic              take_off,
    output logic              take_on,
    output logic              rx_push,
    output logic [DATA_W-1:0] rx_push_data,
    output logic [ERR_W-1:0]  rx_push_err
);
    localparam int NCODES = 2;   // index 0: resume, index 1: stop

    logic [NCODES-1:0][DATA_W-1:0] codes;
    logic [NCODES-1:0]             hit;
    logic [DATA_W-1:0]             eff_data;
    logic                          accepted;
    logic                          is_flow;

    assign codes[0] = xon_code;
    assign codes[1] = xoff_code;
    assign eff_data = rx_break ? '0 : rx_data;

    for (genvar g = 0; g < NCODES; g++) begin : g_cmp
        assign hit[g] = (eff_data == codes[g]);
    end

    always_comb begin
        accepted     = rx_valid && !rx_full;
        is_flow      = auto_en && (|hit);
        take_off     = accepted && auto_en && hit[1];
        take_on      = accepted && auto_en && hit[0] && !hit[1];
        rx_push      = accepted && (!is_flow || transparent);
        rx_push_data = eff_data;
        rx_push_err  = rx_err;
    end

    // R7: an overrun character is neither stored nor used for gating
    p_overrun_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_full) |-> (!rx_push && !take_off && !take_on));

    // R11: a single character never counts as both codes
    p_one_code_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({take_off, take_on}) <= 1);
endmodule

// File: rtl/xtg_pause_fsm.sv
module xtg_pause_fsm
    import xtg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic auto_en,
    input  logic soft_rst,
    input  logic take_off,
    input  logic take_on,
    input  logic tx_busy,
    output logic paused,
    output logic halted,
    output logic flush
);
    gate_regs_t regs_d, regs_q;

    always_comb begin
        regs_d       = regs_q;
        regs_d.flush = 1'b0;
        if (soft_rst) begin
            regs_d.state = GATE_RUN;
            regs_d.flush = 1'b1;
        end else if (!auto_en) begin
            regs_d.state = GATE_RUN;
        end else if (take_off) begin
            regs_d.state = tx_busy ? GATE_DRAIN : GATE_HALT;
        end else if (take_on) begin
            regs_d.state = GATE_RUN;
        end else if (regs_q.state == GATE_DRAIN && !tx_busy) begin
            regs_d.state = GATE_HALT;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q.state <= GATE_RUN;
            regs_q.flush <= 1'b0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign paused = (regs_q.state != GATE_RUN);
    assign halted = (regs_q.state == GATE_HALT);
    assign flush  = regs_q.flush;

    p_xoff_pauses_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_en && take_off && !soft_rst) |=> paused);

    p_drain_waits_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_en && !soft_rst && !take_on && !take_off && paused && !halted && tx_busy)
            |=> (paused && !halted));

    p_xon_resumes_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_en && take_on && !soft_rst) |=> !paused);

    p_soft_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (!paused && flush));

    p_manual_runs_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !auto_en |=> !paused);
endmodule

// File: rtl/xtg_host_gate.sv
module xtg_host_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic auto_en,
    input  logic en_cmd,
    input  logic dis_cmd,
    input  logic running,
    output logic pop_ok
);
    logic host_en_d, host_en_q;

    always_comb begin
        host_en_d = host_en_q;
        if (!auto_en) begin
            if (dis_cmd)     host_en_d = 1'b0;
            else if (en_cmd) host_en_d = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) host_en_q <= 1'b0;
        else        host_en_q <= host_en_d;
    end

    assign pop_ok = auto_en ? running : host_en_q;

    // R6: host commands leave the stored enable alone in automatic mode
    p_cmd_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
        auto_en |=> $stable(host_en_q));
endmodule

// File: rtl/xtg_top.sv
module xtg_top #(
    parameter int DATA_W = 8,
    parameter int ERR_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              auto_en,
    input  logic              transparent,
    input  logic [DATA_W-1:0] xon_code,
    input  logic [DATA_W-1:0] xoff_code,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rx_break,
    input  logic [ERR_W-1:0]  rx_err,
    input  logic              rx_full,
    input  logic              tx_busy,
    input  logic              tx_soft_rst,
    input  logic              host_en_cmd,
    input  logic              host_dis_cmd,
    output logic              rx_push,
    output logic [DATA_W-1:0] rx_push_data,
    output logic [ERR_W-1:0]  rx_push_err,
    output logic              tx_pop_ok,
    output logic              tx_paused,
    output logic              tx_halted,
    output logic              tx_flush
);
    logic take_off, take_on;

    xtg_flow_detect #(.DATA_W(DATA_W), .ERR_W(ERR_W)) u_detect (
        .clk          (clk),
        .rst_n        (rst_n),
        .auto_en      (auto_en),
        .transparent  (transparent),
        .xon_code     (xon_code),
        .xoff_code    (xoff_code),
        .rx_valid     (rx_valid),
        .rx_data      (rx_data),
        .rx_break     (rx_break),
        .rx_err       (rx_err),
        .rx_full      (rx_full),
        .take_off     (take_off),
        .take_on      (take_on),
        .rx_push      (rx_push),
        .rx_push_data (rx_push_data),
        .rx_push_err  (rx_push_err)
    );

    xtg_pause_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .auto_en  (auto_en),
        .soft_rst (tx_soft_rst),
        .take_off (take_off),
        .take_on  (take_on),
        .tx_busy  (tx_busy),
        .paused   (tx_paused),
        .halted   (tx_halted),
        .flush    (tx_flush)
    );

    xtg_host_gate u_host (
        .clk     (clk),
        .rst_n   (rst_n),
        .auto_en (auto_en),
        .en_cmd  (host_en_cmd),
        .dis_cmd (host_dis_cmd),
        .running (!tx_paused),
        .pop_ok  (tx_pop_ok)
    );

    // R9: error flags reach the FIFO unchanged whenever a character is stored
    p_err_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push |-> (rx_push_err == rx_err));
endmodule

// File: tb/xtg_top_bench.sv
module xtg_top_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 0, rst_n = 0;
    logic       auto_en = 0, transparent = 0;
    logic [7:0] xon_code = 8'h11, xoff_code = 8'h13;
    logic       rx_valid = 0, rx_break = 0, rx_full = 0, tx_busy = 0;
    logic [7:0] rx_data = 0;
    logic [1:0] rx_err = 0;
    logic       tx_soft_rst = 0, host_en_cmd = 0, host_dis_cmd = 0;
    logic       rx_push, tx_pop_ok, tx_paused, tx_halted, tx_flush;
    logic [7:0] rx_push_data;
    logic [1:0] rx_push_err;

    int n_checks = 0, n_fail = 0;
    int m_state = 0, m_host = 0, m_flush = 0;  // 0 run, 1 draining, 2 halted
    string tag = "R1";
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xtg_top u_xtg_top (
        .clk(clk), .rst_n(rst_n), .auto_en(auto_en), .transparent(transparent),
        .xon_code(xon_code), .xoff_code(xoff_code), .rx_valid(rx_valid),
        .rx_data(rx_data), .rx_break(rx_break), .rx_err(rx_err), .rx_full(rx_full),
        .tx_busy(tx_busy), .tx_soft_rst(tx_soft_rst), .host_en_cmd(host_en_cmd),
        .host_dis_cmd(host_dis_cmd), .rx_push(rx_push), .rx_push_data(rx_push_data),
        .rx_push_err(rx_push_err), .tx_pop_ok(tx_pop_ok), .tx_paused(tx_paused),
        .tx_halted(tx_halted), .tx_flush(tx_flush)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s/%s %s: actual %0d expected %0d", tag, req, what, act, exp);
        end
    endtask

    // one cycle: inputs already set at the falling edge; check, then advance the model
    task automatic step();
        logic [7:0] eff;
        bit acc, hoff, hon, flow, epush;
        #1;
        eff  = rx_break ? 8'h00 : rx_data;
        acc  = rx_valid && !rx_full;
        hoff = (eff == xoff_code);
        hon  = (eff == xon_code) && !hoff;
        flow = auto_en && (hoff || (eff == xon_code));
        epush = acc && (!flow || transparent);
        chk("R8", "rx_push", rx_push, epush);
        if (epush) begin
            chk("R10", "rx_push_data", rx_push_data, eff);
            chk("R9", "rx_push_err", rx_push_err, rx_err);
        end
        chk("R6", "tx_pop_ok", tx_pop_ok, auto_en ? (m_state == 0) : m_host);
        chk("R2", "tx_paused", tx_paused, m_state != 0);
        chk("R3", "tx_halted", tx_halted, m_state == 2);
        chk("R5", "tx_flush", tx_flush, m_flush);
        @(posedge clk);
        m_flush = 0;
        if (tx_soft_rst) begin m_state = 0; m_flush = 1; end
        else if (!auto_en) m_state = 0;
        else if (acc && hoff) m_state = tx_busy ? 1 : 2;
        else if (acc && hon) m_state = 0;
        else if (m_state == 1 && !tx_busy) m_state = 2;
        if (!auto_en) begin
            if (host_dis_cmd) m_host = 0;
            else if (host_en_cmd) m_host = 1;
        end
        @(negedge clk);
    endtask

    task automatic idle_in();
        rx_valid = 0; rx_break = 0; rx_full = 0; rx_err = 0;
        tx_soft_rst = 0; host_en_cmd = 0; host_dis_cmd = 0;
    endtask

    task automatic offer(input logic [7:0] d);
        rx_valid = 1; rx_data = d; step(); rx_valid = 0;
    endtask

    task automatic do_reset();
        rst_n = 0; m_state = 0; m_host = 0; m_flush = 0;
        @(posedge clk); @(negedge clk);
        rst_n = 1;
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();
        tag = "R1"; idle_in(); step(); step();

        // host mode: commands and inert flow characters (R6, R12)
        tag = "R6"; host_en_cmd = 1; step(); host_en_cmd = 0; step();
        host_en_cmd = 1; host_dis_cmd = 1; step(); idle_in(); step();
        host_en_cmd = 1; step(); idle_in();
        tag = "R12"; offer(8'h13); step(); offer(8'h11); offer(8'h41);

        // automatic mode: stop with drain, host commands ignored, resume
        tag = "R2"; auto_en = 1; transparent = 0; step();
        offer(8'h41);
        tx_busy = 1; offer(8'h13);
        tag = "R3"; step(); host_dis_cmd = 1; step(); host_dis_cmd = 0;
        tx_busy = 0; step(); step();
        tag = "R4"; offer(8'h11); step();
        tag = "R3"; offer(8'h13); step(); offer(8'h11);

        // transparency (R8)
        tag = "R8"; transparent = 1; offer(8'h13); offer(8'h11); offer(8'h55);
        transparent = 0;

        // overrun flow character (R7)
        tag = "R7"; rx_full = 1; offer(8'h13); step(); rx_full = 0;
        offer(8'h13); rx_full = 1; transparent = 1; offer(8'h11); step();
        rx_full = 0; transparent = 0; offer(8'h11);

        // error flags on a flow character (R9)
        tag = "R9"; rx_err = 2'b11; offer(8'h13); rx_err = 2'b01; transparent = 1;
        offer(8'h11); rx_err = 0; transparent = 0; step();

        // break as a zero character (R10)
        tag = "R10"; xoff_code = 8'h00; rx_break = 1; offer(8'hA5); rx_break = 0; step();
        offer(8'h11); auto_en = 0; rx_break = 1; offer(8'h7E); rx_break = 0; auto_en = 1;
        xoff_code = 8'h13;

        // identical codes (R11)
        tag = "R11"; xon_code = 8'h13; offer(8'h13); step(); offer(8'h13); step();
        xon_code = 8'h11; offer(8'h11);

        // soft reset while halted and against a flow character (R5)
        tag = "R5"; offer(8'h13); tx_soft_rst = 1; step(); tx_soft_rst = 0; step();
        offer(8'h13); tx_soft_rst = 1; offer(8'h13); tx_soft_rst = 0; step(); step();

        // leaving automatic mode while halted (R12)
        tag = "R12"; offer(8'h13); auto_en = 0; step(); step(); offer(8'h13); step();

        // asynchronous reset in the middle of activity (R1)
        tag = "R1"; auto_en = 1; tx_busy = 1; offer(8'h13); tx_busy = 0;
        auto_en = 0; do_reset(); step(); step();

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule